// File: doc/BRIEF.md
# Output Fault Retry Supervisor

This block decides when the main and standby outputs of a power module are allowed to run, based on the fault flags that the analog monitors raise. A main-output fault switches off only the main output. The block then waits a fixed gap and tries again. It gives up and latches off once a bounded number of restart attempts has been used. A long stretch of healthy running wipes the attempt history. An over-voltage on the main output latches the output off at once, without any retry.

The standby output has its own over-current handling. It is switched off at once, and it restarts after a fixed off-time, with no limit on the number of attempts. While standby is down, the main output is also held off. The main controller ignores main faults during that time and resumes when standby returns.

The latch and the attempt count are cleared in two ways: by removing input power, or by deasserting and then re-asserting the active-low enable. All times are counted in pulses of an external timebase tick. The defaults assume a 1 ms tick: 20 ms over-current blanking, 10 s retry gap, 5 attempts, 10 min clear window and 1 s standby off-time.

Top module: `fault_retry_sup`

## Requirements
- R1: A main over-current or under-voltage fault seen while the main output runs turns `main_en` off, keeps `sb_en` on, and raises `retry_cnt` by one.
- R2: A standby over-current turns off both `sb_en` and `main_en`. Main faults raised while standby is off are ignored. The main output runs again as soon as standby returns.
- R3: After a main fault, `main_en` comes back on at the RETRY_GAP-th tick, and not at any earlier tick.
- R4: If a main fault arrives when `retry_cnt` already equals MAX_RETRY, the block latches off. `latched` goes high, `main_en` stays low, and `retry_cnt` never exceeds MAX_RETRY.
- R5: While the synchronized enable is deasserted (`en_n` high), `main_en` is low and a latch is kept. When it is re-asserted, `retry_cnt` is cleared to 0, `latched` is cleared, and the main output runs.
- R6: After CLEAR_WIN ticks of uninterrupted fault-free running, `retry_cnt` returns to 0. After one tick fewer, it is unchanged.
- R7: A main over-voltage seen while the main output runs sets `latched` on the next cycle, with no retry and no change to `retry_cnt`.
- R8: The main over-current flag counts as a fault only after it has stayed high for OC_BLANK ticks. If it drops earlier, the count restarts.
- R9: After a standby over-current, `sb_en` comes back at the SB_OFF-th tick, and this repeats for every new overload without limit.
- R10: When `pwr_ok` is low, both enables are low, `latched` is 0 and `retry_cnt` is 0. On power return with enable asserted, both outputs run.
- R11: After reset, `main_en`, `latched` and `retry_cnt` are 0. The main output starts only when `pwr_ok` is high and the enable is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase pulse |
| pwr_ok | input | 1 | Input power present |
| en_n | input | 1 | Active-low main enable, asynchronous |
| main_oc | input | 1 | Main current above static limit |
| main_uv | input | 1 | Main under-voltage |
| main_ov | input | 1 | Main over-voltage |
| sb_oc | input | 1 | Standby over-current |
| main_en | output | 1 | Main output enable |
| sb_en | output | 1 | Standby output enable |
| latched | output | 1 | Main output latched off |
| retry_cnt | output | $clog2(MAX_RETRY+1) | Restart attempts used |

## Verification
The bench counts ticks to the edges of the retry gap, the blanking window, the clear window and the standby off-time. A design that is off by one tick would restart one tick early or late, or clear the history one tick too soon. An over-current pulse that ends one tick short of the blanking window must not shut the output down; a design that kept counting across the gap would. The bench drives the fault sequence up to exactly the attempt limit. A design that latched one attempt too early, or let the count wrap, would be caught there. The bench also raises a main fault while standby is in hiccup. A design that charged that fault to the retry count would show a wrong count when standby comes back.

// File: rtl/frs_pkg.sv
package frs_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_WAIT  = 2'd2,
        ST_LATCH = 2'd3
    } main_st_e;
endpackage

// File: rtl/frs_en_sync.sv
module frs_en_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic en_n,
    output logic en_act,
    output logic en_rise
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d      = q;
        d.s1   = ~en_n;
        d.s2   = q.s1;
        d.prev = q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign en_act  = q.s2;
    assign en_rise = q.s2 & ~q.prev;
endmodule

// File: rtl/frs_oc_blank.sv
module frs_oc_blank #(
    parameter int OC_BLANK = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic arm,
    input  logic oc_raw,
    output logic oc_fault
);
    localparam int BW = $clog2(OC_BLANK + 1);
    localparam logic [BW-1:0] FULL = BW'(OC_BLANK);

    logic [BW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (!arm || !oc_raw)             cnt_d = '0;
        else if (tick && cnt_q != FULL)  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign oc_fault = (cnt_q == FULL);

    // R8: a dropped over-limit flag never leaves a qualified fault behind
    assert_drop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !oc_raw |=> !oc_fault);
endmodule

// File: rtl/frs_sb_hiccup.sv
module frs_sb_hiccup #(
    parameter int SB_OFF = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pwr_ok,
    input  logic sb_oc,
    output logic sb_en
);
    localparam int SW = $clog2(SB_OFF + 1);
    localparam logic [SW-1:0] LAST = SW'(SB_OFF - 1);

    typedef struct packed {
        logic          on;
        logic [SW-1:0] cnt;
    } hic_t;

    hic_t q, d;

    always_comb begin
        d = q;
        if (!pwr_ok) begin
            d.on  = 1'b1;
            d.cnt = '0;
        end else if (q.on) begin
            if (sb_oc) begin
                d.on  = 1'b0;
                d.cnt = '0;
            end
        end else if (tick) begin
            if (q.cnt == LAST) d.on  = 1'b1;
            else               d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{on: 1'b1, cnt: '0};
        else        q <= d;
    end

    assign sb_en = q.on & pwr_ok;

    // R9: an overload on a running standby output cuts it on the next cycle
    assert_sb_trip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_en && sb_oc) |=> !sb_en);
endmodule

// File: rtl/frs_main_ctl.sv
module frs_main_ctl
    import frs_pkg::*;
#(
    parameter int RETRY_GAP = 10000,
    parameter int MAX_RETRY = 5,
    parameter int CLEAR_WIN = 600000,
    parameter int RW        = $clog2(MAX_RETRY + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          pwr_ok,
    input  logic          en_act,
    input  logic          en_rise,
    input  logic          sb_hold,
    input  logic          oc_fault,
    input  logic          uv,
    input  logic          ov,
    output logic          run,
    output logic          latched,
    output logic [RW-1:0] retry_cnt
);
    localparam int GW = $clog2(RETRY_GAP + 1);
    localparam int CW = $clog2(CLEAR_WIN + 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(RETRY_GAP - 1);
    localparam logic [CW-1:0] CLR_LAST = CW'(CLEAR_WIN - 1);
    localparam logic [RW-1:0] CNT_MAX  = RW'(MAX_RETRY);

    typedef struct packed {
        main_st_e      st;
        logic [RW-1:0] cnt;
        logic [GW-1:0] gap;
        logic [CW-1:0] clr;
    } ctl_t;

    ctl_t q, d;

    always_comb begin
        d = q;
        if (!pwr_ok) begin
            d.st  = ST_OFF;
            d.cnt = '0;
            d.gap = '0;
            d.clr = '0;
        end else begin
            unique case (q.st)
                ST_OFF: if (en_act) begin
                    d.st  = ST_RUN;
                    d.clr = '0;
                end
                ST_RUN: begin
                    if (ov && !sb_hold) begin
                        d.st = ST_LATCH;
                    end else if (!en_act) begin
                        d.st = ST_OFF;
                    end else if (!sb_hold) begin
                        if (oc_fault || uv) begin
                            if (q.cnt == CNT_MAX) begin
                                d.st = ST_LATCH;
                            end else begin
                                d.st  = ST_WAIT;
                                d.cnt = q.cnt + 1'b1;
                                d.gap = '0;
                            end
                        end else if (tick) begin
                            if (q.clr == CLR_LAST) begin
                                d.clr = '0;
                                d.cnt = '0;
                            end else begin
                                d.clr = q.clr + 1'b1;
                            end
                        end
                    end
                end
                ST_WAIT: begin
                    if (!en_act) begin
                        d.st = ST_OFF;
                    end else if (tick) begin
                        if (q.gap == GAP_LAST) begin
                            d.st  = ST_RUN;
                            d.clr = '0;
                        end else begin
                            d.gap = q.gap + 1'b1;
                        end
                    end
                end
                ST_LATCH: d.st = ST_LATCH;
                default:  d.st = ST_OFF;
            endcase
            if (en_rise) begin
                d.cnt = '0;
                d.clr = '0;
                if (q.st == ST_LATCH) d.st = ST_RUN;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_OFF, cnt: '0, gap: '0, clr: '0};
        else        q <= d;
    end

    assign run       = (q.st == ST_RUN);
    assign latched   = (q.st == ST_LATCH);
    assign retry_cnt = q.cnt;

    // R4: the attempt count stays within its bound
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        retry_cnt <= CNT_MAX);

    // R5: a re-asserted enable leaves no history behind
    assert_toggle_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rise && pwr_ok) |=> (retry_cnt == '0 && !latched));

    // R10: loss of input power wipes the latch and the count
    assert_pwr_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> (retry_cnt == '0 && !latched && !run));
endmodule

// File: rtl/fault_retry_sup.sv
module fault_retry_sup #(
    parameter int OC_BLANK  = 20,
    parameter int RETRY_GAP = 10000,
    parameter int MAX_RETRY = 5,
    parameter int CLEAR_WIN = 600000,
    parameter int SB_OFF    = 1000,
    parameter int RW        = $clog2(MAX_RETRY + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          pwr_ok,
    input  logic          en_n,
    input  logic          main_oc,
    input  logic          main_uv,
    input  logic          main_ov,
    input  logic          sb_oc,
    output logic          main_en,
    output logic          sb_en,
    output logic          latched,
    output logic [RW-1:0] retry_cnt
);
    logic en_act, en_rise, oc_fault, run;

    frs_en_sync u_sync (
        .clk(clk), .rst_n(rst_n), .en_n(en_n),
        .en_act(en_act), .en_rise(en_rise)
    );

    frs_oc_blank #(.OC_BLANK(OC_BLANK)) u_blank (
        .clk(clk), .rst_n(rst_n), .tick(tick), .arm(main_en),
        .oc_raw(main_oc), .oc_fault(oc_fault)
    );

    frs_sb_hiccup #(.SB_OFF(SB_OFF)) u_sb (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_ok(pwr_ok),
        .sb_oc(sb_oc), .sb_en(sb_en)
    );

    frs_main_ctl #(
        .RETRY_GAP(RETRY_GAP), .MAX_RETRY(MAX_RETRY),
        .CLEAR_WIN(CLEAR_WIN), .RW(RW)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_ok(pwr_ok),
        .en_act(en_act), .en_rise(en_rise), .sb_hold(~sb_en),
        .oc_fault(oc_fault), .uv(main_uv), .ov(main_ov),
        .run(run), .latched(latched), .retry_cnt(retry_cnt)
    );

    assign main_en = run & sb_en;

    // R2: main never runs while standby is down
    assert_sb_down_main_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sb_en |-> !main_en);

    // R7: over-voltage on a running main output latches next cycle
    assert_ov_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (main_en && main_ov) |=> latched);

    // R4: a latched block never drives the main output
    assert_latch_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        latched |-> !main_en);
endmodule

// File: tb/fault_retry_sup_tb.sv
module fault_retry_sup_tb;
    localparam int CLK_PERIOD = 10;
    localparam int P_BLANK = 3;
    localparam int P_GAP   = 4;
    localparam int P_MAX   = 3;
    localparam int P_CLR   = 8;
    localparam int P_SBOFF = 2;
    localparam int RW      = $clog2(P_MAX + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, pwr_ok = 1'b0, en_n = 1'b1;
    logic main_oc = 1'b0, main_uv = 1'b0, main_ov = 1'b0, sb_oc = 1'b0;
    logic main_en, sb_en, latched;
    logic [RW-1:0] retry_cnt;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_retry_sup #(
        .OC_BLANK(P_BLANK), .RETRY_GAP(P_GAP), .MAX_RETRY(P_MAX),
        .CLEAR_WIN(P_CLR), .SB_OFF(P_SBOFF)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_ok(pwr_ok), .en_n(en_n),
        .main_oc(main_oc), .main_uv(main_uv), .main_ov(main_ov), .sb_oc(sb_oc),
        .main_en(main_en), .sb_en(sb_en), .latched(latched), .retry_cnt(retry_cnt)
    );

    task automatic chk(input int act, input int exp, input string req, input string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
        settle(2);
    endtask

    task automatic pulse_uv();
        @(negedge clk) main_uv = 1'b1;
        @(negedge clk) main_uv = 1'b0;
        settle(2);
    endtask

    task automatic t_reset();
        settle(2);
        chk(main_en, 0, "R11", "main_en in reset");
        chk(latched, 0, "R11", "latched in reset");
        chk(retry_cnt, 0, "R11", "retry_cnt in reset");
        rst_n = 1'b1;
        settle(4);
        chk(main_en, 0, "R11", "main_en before power");
        pwr_ok = 1'b1;
        en_n   = 1'b0;
        settle(5);
        chk(main_en, 1, "R11", "main_en after power and enable");
        chk(sb_en, 1, "R11", "sb_en after power");
    endtask

    task automatic t_main_fault();
        pulse_uv();
        chk(main_en, 0, "R1", "main_en after uv");
        chk(sb_en, 1, "R1", "sb_en after uv");
        chk(retry_cnt, 1, "R1", "retry_cnt after uv");
        ticks(P_GAP - 1);
        chk(main_en, 0, "R3", "main_en one tick before gap end");
        ticks(1);
        chk(main_en, 1, "R3", "main_en at gap end");
    endtask

    task automatic t_oc_blank();
        main_oc = 1'b1;
        ticks(P_BLANK - 1);
        main_oc = 1'b0;
        settle(2);
        chk(main_en, 1, "R8", "short over-limit ignored");
        main_oc = 1'b1;
        ticks(P_BLANK - 1);
        chk(main_en, 1, "R8", "count restarted after drop");
        ticks(1);
        chk(main_en, 0, "R8", "sustained over-limit trips");
        chk(retry_cnt, 2, "R8", "retry_cnt after oc trip");
        main_oc = 1'b0;
        ticks(P_GAP);
        chk(main_en, 1, "R3", "restart after oc");
    endtask

    task automatic t_clear_win();
        ticks(P_CLR - 1);
        chk(retry_cnt, 2, "R6", "count held before window end");
        ticks(1);
        chk(retry_cnt, 0, "R6", "count cleared at window end");
    endtask

    task automatic t_latch();
        for (int k = 0; k < P_MAX; k++) begin
            pulse_uv();
            ticks(P_GAP);
        end
        chk(retry_cnt, P_MAX, "R4", "count at limit");
        chk(main_en, 1, "R4", "still running at limit");
        pulse_uv();
        chk(latched, 1, "R4", "latched after extra fault");
        chk(retry_cnt, P_MAX, "R4", "count not past limit");
        ticks(P_GAP + 2);
        chk(main_en, 0, "R4", "no restart when latched");
        chk(sb_en, 1, "R1", "standby alive while latched");
    endtask

    task automatic t_toggle();
        en_n = 1'b1;
        settle(5);
        chk(latched, 1, "R5", "latch kept while disabled");
        chk(main_en, 0, "R5", "main off while disabled");
        en_n = 1'b0;
        settle(5);
        chk(latched, 0, "R5", "latch cleared by toggle");
        chk(retry_cnt, 0, "R5", "count cleared by toggle");
        chk(main_en, 1, "R5", "main running after toggle");
    endtask

    task automatic t_ov();
        pulse_uv();
        ticks(P_GAP);
        @(negedge clk) main_ov = 1'b1;
        @(negedge clk) main_ov = 1'b0;
        chk(latched, 1, "R7", "latched next cycle after ov");
        chk(retry_cnt, 1, "R7", "count unchanged by ov");
        ticks(P_GAP + 1);
        chk(main_en, 0, "R7", "no retry after ov");
        pwr_ok = 1'b0;
        settle(2);
        chk(latched, 0, "R10", "latch cleared by power loss");
        chk(retry_cnt, 0, "R10", "count cleared by power loss");
        chk(sb_en, 0, "R10", "standby off without power");
        chk(main_en, 0, "R10", "main off without power");
        pwr_ok = 1'b1;
        settle(3);
        chk(main_en, 1, "R10", "main back on power return");
        chk(sb_en, 1, "R10", "standby back on power return");
    endtask

    task automatic t_hiccup();
        for (int k = 0; k < 3; k++) begin
            @(negedge clk) sb_oc = 1'b1;
            @(negedge clk) sb_oc = 1'b0;
            settle(1);
            chk(sb_en, 0, "R9", "standby off on overload");
            chk(main_en, 0, "R2", "main off with standby");
            pulse_uv();
            ticks(P_SBOFF - 1);
            chk(sb_en, 0, "R9", "standby off one tick early");
            ticks(1);
            chk(sb_en, 1, "R9", "standby back at off-time end");
            chk(main_en, 1, "R2", "main resumes with standby");
            chk(retry_cnt, 0, "R2", "main fault during hold ignored");
        end
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_main_fault();
                t_oc_blank();
                t_clear_win();
                t_latch();
                t_toggle();
                t_ov();
                t_hiccup();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule